// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block holds the sixteen 32-bit architectural registers of a processor core, together with the current program status word and one saved status word for each privileged mode that owns one. A 5-bit mode number, taken from the low bits of the current status word, picks a register bank. Some registers then have physically separate copies per bank: the fast-interrupt mode has its own r8 to r14, the other privileged modes own only r13 and r14, and everything else comes from the shared user set. System mode works on the user set.

The core reads two registers and writes one per cycle in the current mode. A debug port names any mode and reaches that mode's copy of a register without touching the live mode. Status writes carry a 4-bit field mask and obey privilege rules. A separate mode-load input forces a new mode at the next clock edge, and any register write in that same cycle still lands in the bank of the mode that was current before the edge.

Top module: `mode_bank_regfile`

## Requirements
- R1: The mode number maps to a bank as follows. 0 and 16 select user, 1 and 17 fast-interrupt, 2 and 18 interrupt, 3 and 19 supervisor, 23 abort, 27 undefined and 31 system. Every other value selects a dummy bank.
- R2: Registers r0 to r7 and r15 are the same in every mode. r8 to r14 are private to the fast-interrupt bank. r13 and r14 are private to each of the interrupt, supervisor, abort and undefined banks. User and system modes share the user copies.
- R3: Writing r8 to r12 in fast-interrupt mode leaves the user values intact, and those user values are seen again after leaving that mode.
- R4: The debug port reads or writes the copy of a register that belongs to `dbg_mode`, and the current mode does not change. If a core write and a debug write hit the same physical register in one cycle, the core write wins.
- R5: In a dummy-bank mode, r8 to r14 read as zero and writes to them are discarded. r0 to r7 and r15 behave as in user mode.
- R6: In user mode, a current-status write changes only bits 31:28, and only when mask bit 3 is set.
- R7: In any mode other than user, a status write with mask 4'b1001 replaces all 32 bits. Otherwise mask bit 0 replaces bits 7:0. Failing that, mask bit 3 replaces bits 31:28. Failing both, nothing changes.
- R8: Saved status words exist only for the fast-interrupt, interrupt, supervisor, abort and undefined banks, and a saved-status write follows the masking of R7. In any other bank, saved-status reads return zero and writes are ignored.
- R9: `xfer_priv` is high exactly when bits 1:0 of the current mode are not both zero.
- R10: The current mode is `cpsr[4:0]`. When `mode_ld` is high, the mode becomes `mode_nxt` at the next edge, and this overrides the mode field of a status write in the same cycle. A register write in that cycle uses the old mode's bank.
- R11: After reset, every register copy and saved status word is zero and `cpsr` is 32'h0000_0013.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_ld | input | 1 | Force a new mode at the next edge |
| mode_nxt | input | 5 | Mode to load |
| rd_a_idx | input | 4 | Read port A register number |
| rd_a_data | output | 32 | Read port A data, current mode |
| rd_b_idx | input | 4 | Read port B register number |
| rd_b_data | output | 32 | Read port B data, current mode |
| wr_en | input | 1 | Core write enable |
| wr_idx | input | 4 | Core write register number |
| wr_data | input | 32 | Core write data |
| dbg_mode | input | 5 | Mode whose copy the debug port reaches |
| dbg_idx | input | 4 | Debug register number |
| dbg_we | input | 1 | Debug write enable |
| dbg_wdata | input | 32 | Debug write data |
| dbg_rdata | output | 32 | Debug read data |
| dbg_spsr | output | 32 | Saved status word of `dbg_mode`, zero if none |
| psr_we | input | 1 | Status write enable |
| psr_spsr | input | 1 | 1 targets the current saved status, 0 the current status |
| psr_mask | input | 4 | Field mask |
| psr_wdata | input | 32 | Status write data |
| cpsr | output | 32 | Current status word, mode in bits 4:0 |
| spsr | output | 32 | Saved status word of the current bank, zero if none |
| xfer_priv | output | 1 | High when mode bits 1:0 are nonzero |

## Verification
The assertions assume an active-low reset held for at least one edge before any enable is raised. They also assume that the debug write is low whenever they reason about what a core write leaves untouched, because a debug write can legally modify any copy. The stimulus meets the first condition by holding every enable low during reset. It meets the second by driving debug writes only on some random cycles, so the guarded properties still see many cycles without them. Random status writes can load any 5-bit mode, including dummy and unlisted values, so the mode-load input is used often enough to bring the file back into the listed modes.

// File: rtl/mbr_pkg.sv
`timescale 1ns/1ps
package mbr_pkg;
  localparam int MODE_W    = 5;
  localparam int IDX_W     = 4;
  localparam int PSR_W     = 32;
  localparam int NUM_ARCH  = 16;
  localparam int FIQ_LO    = 8;
  localparam int BANK_HI   = 14;
  localparam int PRV_LO    = 13;
  localparam int NUM_FIQ   = BANK_HI - FIQ_LO + 1;
  localparam int NUM_PRVBK = 4;
  localparam int NUM_PRV   = BANK_HI - PRV_LO + 1;
  localparam int NUM_SPSR  = 5;
  localparam int SPSR_IW   = $clog2(NUM_SPSR);
  localparam logic [PSR_W-1:0] PSR_RESET = 32'h0000_0013;

  typedef enum logic [2:0] {
    BK_USR, BK_FIQ, BK_IRQ, BK_SVC, BK_ABT, BK_UND, BK_SYS, BK_NUL
  } bank_e;

  typedef enum logic [1:0] {LOC_USR, LOC_FIQ, LOC_PRV, LOC_NUL} loc_kind_e;

  typedef struct packed {
    loc_kind_e        kind;
    logic [IDX_W-1:0] slot;
  } loc_t;

  typedef struct packed {
    logic               ok;
    logic [SPSR_IW-1:0] n;
  } spsr_sel_t;

  function automatic bank_e bank_of(input logic [MODE_W-1:0] m);
    bank_e b;
    case (m)
      5'd0,  5'd16: b = BK_USR;
      5'd1,  5'd17: b = BK_FIQ;
      5'd2,  5'd18: b = BK_IRQ;
      5'd3,  5'd19: b = BK_SVC;
      5'd23:        b = BK_ABT;
      5'd27:        b = BK_UND;
      5'd31:        b = BK_SYS;
      default:      b = BK_NUL;
    endcase
    return b;
  endfunction

  // Physical location of an architectural register in a bank.
  function automatic loc_t locate(input bank_e b, input logic [IDX_W-1:0] idx);
    loc_t       l;
    logic [2:0] rel;
    l.kind = LOC_USR;
    l.slot = idx;
    rel    = 3'(b) - 3'(BK_IRQ);
    if (idx >= 4'(FIQ_LO) && idx <= 4'(BANK_HI)) begin
      if (b == BK_FIQ) begin
        l.kind = LOC_FIQ;
        l.slot = idx - 4'(FIQ_LO);
      end else if (b == BK_NUL) begin
        l.kind = LOC_NUL;
      end else if (idx >= 4'(PRV_LO) && b inside {BK_IRQ, BK_SVC, BK_ABT, BK_UND}) begin
        l.kind = LOC_PRV;
        l.slot = {1'b0, rel[1:0], idx == 4'(BANK_HI)};
      end
    end
    return l;
  endfunction

  function automatic spsr_sel_t spsr_of(input bank_e b);
    spsr_sel_t s;
    s.ok = b inside {BK_FIQ, BK_IRQ, BK_SVC, BK_ABT, BK_UND};
    s.n  = SPSR_IW'(3'(b) - 3'(BK_FIQ));
    return s;
  endfunction

  // Masked status update under the privilege rules.
  function automatic logic [PSR_W-1:0] psr_merge(input logic [PSR_W-1:0] old_v,
                                                input logic [PSR_W-1:0] new_v,
                                                input logic [3:0]       mask,
                                                input logic             priv);
    logic [PSR_W-1:0] r;
    r = old_v;
    if (!priv) begin
      if (mask[3]) r[31:28] = new_v[31:28];
    end else if (mask == 4'b1001) begin
      r = new_v;
    end else if (mask[0]) begin
      r[7:0] = new_v[7:0];
    end else if (mask[3]) begin
      r[31:28] = new_v[31:28];
    end
    return r;
  endfunction
endpackage

// File: rtl/mbr_gpr_store.sv
`timescale 1ns/1ps
module mbr_gpr_store
  import mbr_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  loc_t          ra_loc,
  input  loc_t          rb_loc,
  input  loc_t          rd_loc,
  output logic [DW-1:0] ra_q,
  output logic [DW-1:0] rb_q,
  output logic [DW-1:0] rd_q,
  input  logic          cw_en,
  input  loc_t          cw_loc,
  input  logic [DW-1:0] cw_wd,
  input  logic          dw_en,
  input  loc_t          dw_loc,
  input  logic [DW-1:0] dw_wd
);
  localparam int NUM_PRV_ALL = NUM_PRVBK * NUM_PRV;

  logic [DW-1:0] usr_q [NUM_ARCH];
  logic [DW-1:0] fiq_q [NUM_FIQ];
  logic [DW-1:0] prv_q [NUM_PRV_ALL];

  function automatic logic [DW-1:0] fetch(input loc_t l);
    case (l.kind)
      LOC_USR: fetch = usr_q[l.slot];
      LOC_FIQ: fetch = fiq_q[l.slot[2:0]];
      LOC_PRV: fetch = prv_q[l.slot[2:0]];
      default: fetch = '0;
    endcase
  endfunction

  assign ra_q = fetch(ra_loc);
  assign rb_q = fetch(rb_loc);
  assign rd_q = fetch(rd_loc);

  // Debug write applied first so a core write to the same cell wins.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ARCH; i++)    usr_q[i] <= '0;
      for (int i = 0; i < NUM_FIQ; i++)     fiq_q[i] <= '0;
      for (int i = 0; i < NUM_PRV_ALL; i++) prv_q[i] <= '0;
    end else begin
      if (dw_en) begin
        case (dw_loc.kind)
          LOC_USR: usr_q[dw_loc.slot]      <= dw_wd;
          LOC_FIQ: fiq_q[dw_loc.slot[2:0]] <= dw_wd;
          LOC_PRV: prv_q[dw_loc.slot[2:0]] <= dw_wd;
          default: ;
        endcase
      end
      if (cw_en) begin
        case (cw_loc.kind)
          LOC_USR: usr_q[cw_loc.slot]      <= cw_wd;
          LOC_FIQ: fiq_q[cw_loc.slot[2:0]] <= cw_wd;
          LOC_PRV: prv_q[cw_loc.slot[2:0]] <= cw_wd;
          default: ;
        endcase
      end
    end
  end

  // Flattened views for the checks below.
  logic [NUM_ARCH*DW-1:0]    usr_flat;
  logic [NUM_FIQ*DW-1:0]     fiq_flat;
  logic [NUM_PRV_ALL*DW-1:0] prv_flat;
  for (genvar g = 0; g < NUM_ARCH; g++) begin : g_usr_flat
    assign usr_flat[g*DW +: DW] = usr_q[g];
  end
  for (genvar g = 0; g < NUM_FIQ; g++) begin : g_fiq_flat
    assign fiq_flat[g*DW +: DW] = fiq_q[g];
  end
  for (genvar g = 0; g < NUM_PRV_ALL; g++) begin : g_prv_flat
    assign prv_flat[g*DW +: DW] = prv_q[g];
  end

  // R3
  usr_shadow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cw_en && cw_loc.kind != LOC_USR && !dw_en) |=>
      $stable(usr_flat[13*DW-1:FIQ_LO*DW]));

  // R5
  sink_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cw_en && cw_loc.kind == LOC_NUL && !dw_en) |=>
      ($stable(usr_flat) && $stable(fiq_flat) && $stable(prv_flat)));

  // R4
  core_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cw_en && dw_en && cw_loc == dw_loc && cw_loc.kind == LOC_USR) |=>
      usr_q[$past(cw_loc.slot)] == $past(cw_wd));
endmodule

// File: rtl/mbr_psr_unit.sv
`timescale 1ns/1ps
module mbr_psr_unit
  import mbr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psr_we,
  input  logic              psr_spsr,
  input  logic [3:0]        psr_mask,
  input  logic [PSR_W-1:0]  psr_wdata,
  input  logic              mode_ld,
  input  logic [MODE_W-1:0] mode_nxt,
  input  bank_e             dbg_bank,
  output bank_e             cur_bank,
  output logic [PSR_W-1:0]  cpsr_q,
  output logic [PSR_W-1:0]  cur_spsr,
  output logic [PSR_W-1:0]  dbg_spsr
);
  logic [PSR_W-1:0] spsr_q [NUM_SPSR];
  logic [PSR_W-1:0] cpsr_d;
  spsr_sel_t        cur_sel, dbg_sel;
  logic             is_priv, spsr_wr_ok;

  assign cur_bank   = bank_of(cpsr_q[MODE_W-1:0]);
  assign is_priv    = (cur_bank != BK_USR);
  assign cur_sel    = spsr_of(cur_bank);
  assign dbg_sel    = spsr_of(dbg_bank);
  assign spsr_wr_ok = psr_we && psr_spsr && cur_sel.ok;

  always_comb begin
    cpsr_d = cpsr_q;
    if (psr_we && !psr_spsr) cpsr_d = psr_merge(cpsr_q, psr_wdata, psr_mask, is_priv);
    if (mode_ld) cpsr_d[MODE_W-1:0] = mode_nxt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpsr_q <= PSR_RESET;
      for (int i = 0; i < NUM_SPSR; i++) spsr_q[i] <= '0;
    end else begin
      cpsr_q <= cpsr_d;
      if (spsr_wr_ok)
        spsr_q[cur_sel.n] <= psr_merge(spsr_q[cur_sel.n], psr_wdata, psr_mask, 1'b1);
    end
  end

  assign cur_spsr = cur_sel.ok ? spsr_q[cur_sel.n] : '0;
  assign dbg_spsr = dbg_sel.ok ? spsr_q[dbg_sel.n] : '0;

  logic [NUM_SPSR*PSR_W-1:0] spsr_flat;
  for (genvar g = 0; g < NUM_SPSR; g++) begin : g_spsr_flat
    assign spsr_flat[g*PSR_W +: PSR_W] = spsr_q[g];
  end

  // R6
  user_flags_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (psr_we && !psr_spsr && cur_bank == BK_USR && !mode_ld) |=>
      $stable(cpsr_q[27:0]));

  // R10
  mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_ld |=> cpsr_q[MODE_W-1:0] == $past(mode_nxt));

  // R8
  spsr_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (psr_we && psr_spsr && !cur_sel.ok) |=> $stable(spsr_flat));
endmodule

// File: rtl/mode_bank_regfile.sv
`timescale 1ns/1ps
module mode_bank_regfile
  import mbr_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_ld,
  input  logic [MODE_W-1:0] mode_nxt,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output logic [DW-1:0]     rd_a_data,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [DW-1:0]     rd_b_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DW-1:0]     wr_data,
  input  logic [MODE_W-1:0] dbg_mode,
  input  logic [IDX_W-1:0]  dbg_idx,
  input  logic              dbg_we,
  input  logic [DW-1:0]     dbg_wdata,
  output logic [DW-1:0]     dbg_rdata,
  output logic [PSR_W-1:0]  dbg_spsr,
  input  logic              psr_we,
  input  logic              psr_spsr,
  input  logic [3:0]        psr_mask,
  input  logic [PSR_W-1:0]  psr_wdata,
  output logic [PSR_W-1:0]  cpsr,
  output logic [PSR_W-1:0]  spsr,
  output logic              xfer_priv
);
  bank_e cur_bank, dbg_bank;
  loc_t  ra_loc, rb_loc, dbg_loc, wr_loc;

  assign dbg_bank = bank_of(dbg_mode);
  // Every location is taken from the bank of the mode in force before the edge.
  assign ra_loc   = locate(cur_bank, rd_a_idx);
  assign rb_loc   = locate(cur_bank, rd_b_idx);
  assign wr_loc   = locate(cur_bank, wr_idx);
  assign dbg_loc  = locate(dbg_bank, dbg_idx);

  mbr_psr_unit u_psr (
    .clk       (clk),
    .rst_n     (rst_n),
    .psr_we    (psr_we),
    .psr_spsr  (psr_spsr),
    .psr_mask  (psr_mask),
    .psr_wdata (psr_wdata),
    .mode_ld   (mode_ld),
    .mode_nxt  (mode_nxt),
    .dbg_bank  (dbg_bank),
    .cur_bank  (cur_bank),
    .cpsr_q    (cpsr),
    .cur_spsr  (spsr),
    .dbg_spsr  (dbg_spsr)
  );

  mbr_gpr_store #(.DW(DW)) u_gpr (
    .clk    (clk),
    .rst_n  (rst_n),
    .ra_loc (ra_loc),
    .rb_loc (rb_loc),
    .rd_loc (dbg_loc),
    .ra_q   (rd_a_data),
    .rb_q   (rd_b_data),
    .rd_q   (dbg_rdata),
    .cw_en  (wr_en),
    .cw_loc (wr_loc),
    .cw_wd  (wr_data),
    .dw_en  (dbg_we),
    .dw_loc (dbg_loc),
    .dw_wd  (dbg_wdata)
  );

  assign xfer_priv = |cpsr[1:0];
endmodule

// File: tb/mode_bank_regfile_test.sv
`timescale 1ns/1ps
module mode_bank_regfile_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode_ld;
  logic [4:0]  mode_nxt;
  logic [3:0]  rd_a_idx, rd_b_idx, wr_idx, dbg_idx;
  logic [31:0] rd_a_data, rd_b_data, wr_data, dbg_wdata, dbg_rdata, dbg_spsr;
  logic        wr_en, dbg_we, psr_we, psr_spsr, xfer_priv;
  logic [4:0]  dbg_mode;
  logic [3:0]  psr_mask;
  logic [31:0] psr_wdata, cpsr, spsr;

  always #2.5 clk = ~clk;

  mode_bank_regfile uut (
    .clk(clk), .rst_n(rst_n), .mode_ld(mode_ld), .mode_nxt(mode_nxt),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data), .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .dbg_mode(dbg_mode), .dbg_idx(dbg_idx), .dbg_we(dbg_we), .dbg_wdata(dbg_wdata),
    .dbg_rdata(dbg_rdata), .dbg_spsr(dbg_spsr),
    .psr_we(psr_we), .psr_spsr(psr_spsr), .psr_mask(psr_mask), .psr_wdata(psr_wdata),
    .cpsr(cpsr), .spsr(spsr), .xfer_priv(xfer_priv)
  );

  int  checks = 0;
  int  failures = 0;
  bit  done = 0;

  // Reference state, kept per architectural copy.
  bit [31:0] m_usr [16];
  bit [31:0] m_fiq [7];
  bit [31:0] m_prv [4][2];
  bit [31:0] m_spsr [5];
  bit [31:0] m_cpsr;

  // 0 user, 1 fiq, 2 irq, 3 svc, 4 abort, 5 undef, 6 system, 7 dummy
  function automatic int bk(bit [4:0] m);
    case (m)
      0, 16: return 0;
      1, 17: return 1;
      2, 18: return 2;
      3, 19: return 3;
      23:    return 4;
      27:    return 5;
      31:    return 6;
      default: return 7;
    endcase
  endfunction

  function automatic bit [31:0] m_rd(bit [4:0] m, int idx);
    int b = bk(m);
    if (idx < 8 || idx == 15) return m_usr[idx];
    if (b == 1) return m_fiq[idx-8];
    if (b == 7) return 32'h0;
    if (idx >= 13 && b >= 2 && b <= 5) return m_prv[b-2][idx-13];
    return m_usr[idx];
  endfunction

  task automatic m_wr(bit [4:0] m, int idx, bit [31:0] d);
    int b = bk(m);
    if (idx < 8 || idx == 15) m_usr[idx] = d;
    else if (b == 1) m_fiq[idx-8] = d;
    else if (b == 7) ;
    else if (idx >= 13 && b >= 2 && b <= 5) m_prv[b-2][idx-13] = d;
    else m_usr[idx] = d;
  endtask

  function automatic bit [31:0] m_spsr_rd(bit [4:0] m);
    int b = bk(m);
    if (b >= 1 && b <= 5) return m_spsr[b-1];
    return 32'h0;
  endfunction

  function automatic bit [31:0] m_merge(bit [31:0] o, bit [31:0] n, bit [3:0] k, bit priv);
    bit [31:0] en;
    if (!priv)          en = k[3] ? 32'hF000_0000 : 32'h0;
    else if (k == 4'd9) en = 32'hFFFF_FFFF;
    else if (k[0])      en = 32'h0000_00FF;
    else if (k[3])      en = 32'hF000_0000;
    else                en = 32'h0;
    return (o & ~en) | (n & en);
  endfunction

  task automatic chk(string tag, string what, bit [31:0] act, bit [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    mode_ld = 0; mode_nxt = 0; wr_en = 0; wr_idx = 0; wr_data = 0;
    dbg_we = 0; dbg_wdata = 0; psr_we = 0; psr_spsr = 0; psr_mask = 0; psr_wdata = 0;
  endtask

  // Compare all outputs against the reference, then advance one edge.
  task automatic step(string tag);
    bit [4:0] cur;
    int       b;
    bit [31:0] nc;
    #1;
    cur = m_cpsr[4:0];
    chk(tag, "rd_a", rd_a_data, m_rd(cur, int'(rd_a_idx)));
    chk(tag, "rd_b", rd_b_data, m_rd(cur, int'(rd_b_idx)));
    chk(tag, "dbg_rdata", dbg_rdata, m_rd(dbg_mode, int'(dbg_idx)));
    chk(tag, "dbg_spsr", dbg_spsr, m_spsr_rd(dbg_mode));
    chk(tag, "cpsr", cpsr, m_cpsr);
    chk(tag, "spsr", spsr, m_spsr_rd(cur));
    chk("R9", "xfer_priv", {31'b0, xfer_priv}, {31'b0, (cur[1:0] != 2'b00)});
    b = bk(cur);
    if (dbg_we) m_wr(dbg_mode, int'(dbg_idx), dbg_wdata);
    if (wr_en)  m_wr(cur, int'(wr_idx), wr_data);
    if (psr_we && psr_spsr && b >= 1 && b <= 5)
      m_spsr[b-1] = m_merge(m_spsr[b-1], psr_wdata, psr_mask, 1'b1);
    nc = m_cpsr;
    if (psr_we && !psr_spsr) nc = m_merge(m_cpsr, psr_wdata, psr_mask, b != 0);
    if (mode_ld) nc[4:0] = mode_nxt;
    m_cpsr = nc;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic go_mode(bit [4:0] m, string tag);
    idle(); mode_ld = 1; mode_nxt = m; step(tag);
  endtask
  task automatic do_wr(int idx, bit [31:0] d, string tag);
    idle(); wr_en = 1; wr_idx = 4'(idx); wr_data = d; step(tag);
  endtask
  task automatic do_rd(int a, int b, string tag);
    idle(); rd_a_idx = 4'(a); rd_b_idx = 4'(b); step(tag);
  endtask
  task automatic do_dbg(bit [4:0] m, int idx, bit we, bit [31:0] d, string tag);
    idle(); dbg_mode = m; dbg_idx = 4'(idx); dbg_we = we; dbg_wdata = d; step(tag);
  endtask
  task automatic do_psr(bit sp, bit [3:0] k, bit [31:0] d, string tag);
    idle(); psr_we = 1; psr_spsr = sp; psr_mask = k; psr_wdata = d; step(tag);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit [4:0] modes [7] = '{5'd16, 5'd17, 5'd18, 5'd19, 5'd23, 5'd27, 5'd31};
    void'($urandom(32'h1CE5_0B17));
    idle(); rd_a_idx = 0; rd_b_idx = 0; dbg_mode = 5'd19; dbg_idx = 0;
    rst_n = 0;
    foreach (m_usr[i]) m_usr[i] = 0;
    foreach (m_fiq[i]) m_fiq[i] = 0;
    foreach (m_prv[i, j]) m_prv[i][j] = 0;
    foreach (m_spsr[i]) m_spsr[i] = 0;
    m_cpsr = 32'h13;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R11: reset state visible through the debug port for every listed mode
    for (int k = 0; k < 7; k++)
      for (int r = 0; r < 16; r += 3) do_dbg(modes[k], r, 0, 0, "R11");

    // R1: every mode value, tag r13 and read it back
    for (int m = 0; m < 32; m++) begin
      go_mode(5'(m), "R1");
      do_wr(13, 32'h1000 + m, "R1");
      do_rd(13, 14, "R1");
    end
    for (int m = 0; m < 32; m++) do_dbg(5'(m), 13, 0, 0, "R1");

    // R2: r0..r7/r15 shared, user and system alike
    go_mode(5'd16, "R2");
    for (int r = 0; r < 16; r++) do_wr(r, 32'hA000_0000 + r, "R2");
    go_mode(5'd31, "R2");
    for (int r = 0; r < 16; r += 2) do_rd(r, r + 1, "R2");
    go_mode(5'd18, "R2");
    for (int r = 0; r < 16; r += 2) do_rd(r, r + 1, "R2");

    // R3: fast-interrupt copies of r8..r12 leave user values alone
    go_mode(5'd17, "R3");
    for (int r = 8; r < 15; r++) do_wr(r, 32'hF100_0000 + r, "R3");
    for (int r = 8; r < 15; r += 2) do_rd(r, r + 1, "R3");
    go_mode(5'd16, "R3");
    for (int r = 8; r < 15; r += 2) do_rd(r, r + 1, "R3");

    // R5: dummy bank sink
    go_mode(5'd5, "R5");
    do_wr(9, 32'hDEAD_0009, "R5");
    do_wr(13, 32'hDEAD_000D, "R5");
    do_wr(3, 32'hBEEF_0003, "R5");
    do_rd(9, 13, "R5");
    do_rd(3, 12, "R5");
    go_mode(5'd16, "R5");
    do_rd(9, 13, "R5");

    // R4: debug reach and collision priority
    go_mode(5'd19, "R4");
    do_dbg(5'd17, 10, 1, 32'h0D0D_0010, "R4");
    do_dbg(5'd17, 10, 0, 0, "R4");
    do_rd(10, 13, "R4");
    idle(); wr_en = 1; wr_idx = 13; wr_data = 32'hC0DE_0013;
    dbg_mode = 5'd19; dbg_idx = 13; dbg_we = 1; dbg_wdata = 32'hBAD0_0013; step("R4");
    idle(); wr_en = 1; wr_idx = 2; wr_data = 32'hC0DE_0002;
    dbg_mode = 5'd27; dbg_idx = 2; dbg_we = 1; dbg_wdata = 32'hBAD0_0002; step("R4");
    do_rd(13, 2, "R4");

    // R7: privileged masks
    do_psr(0, 4'd9, 32'hA000_00D3, "R7");
    do_psr(0, 4'd1, 32'h5555_0053, "R7");
    do_psr(0, 4'd8, 32'h5FFF_FF1F, "R7");
    do_psr(0, 4'd0, 32'hFFFF_FFFF, "R7");
    do_psr(0, 4'd6, 32'hFFFF_FFFF, "R7");
    do_rd(0, 0, "R7");

    // R8: saved status words
    do_psr(1, 4'd9, 32'h1234_5678, "R8");
    do_psr(1, 4'd1, 32'hFFFF_FF99, "R8");
    go_mode(5'd18, "R8");
    do_psr(1, 4'd8, 32'h9000_0000, "R8");
    go_mode(5'd31, "R8");
    do_psr(1, 4'd9, 32'hFFFF_FFFF, "R8");
    go_mode(5'd16, "R8");
    do_psr(1, 4'd9, 32'hFFFF_FFFF, "R8");
    go_mode(5'd9, "R8");
    do_psr(1, 4'd9, 32'hFFFF_FFFF, "R8");
    for (int m = 0; m < 32; m++) do_dbg(5'(m), 0, 0, 0, "R8");

    // R6: user mode flags only
    go_mode(5'd16, "R6");
    do_psr(0, 4'd9, 32'h5000_00DF, "R6");
    do_psr(0, 4'd1, 32'hF000_001F, "R6");
    do_psr(0, 4'd8, 32'hA0FF_FF13, "R6");
    do_rd(0, 0, "R6");

    // R10: mode load with a write and a status write in the same cycle
    go_mode(5'd19, "R10");
    idle(); mode_ld = 1; mode_nxt = 5'd18; wr_en = 1; wr_idx = 13; wr_data = 32'h0DD0_5C13;
    step("R10");
    do_rd(13, 14, "R10");
    do_dbg(5'd19, 13, 0, 0, "R10");
    idle(); mode_ld = 1; mode_nxt = 5'd23; psr_we = 1; psr_mask = 4'd9; psr_wdata = 32'h6000_00D1;
    step("R10");
    do_rd(13, 8, "R10");

    // Random mix
    for (int n = 0; n < 4000; n++) begin
      idle();
      rd_a_idx = 4'($urandom);
      rd_b_idx = 4'($urandom);
      dbg_mode = ($urandom % 4 == 0) ? 5'($urandom) : modes[$urandom % 7];
      dbg_idx  = 4'($urandom);
      if ($urandom % 3 == 0) begin
        mode_ld  = 1;
        mode_nxt = ($urandom % 6 == 0) ? 5'($urandom) : modes[$urandom % 7];
      end
      wr_en     = ($urandom % 2 == 0);
      wr_idx    = 4'($urandom);
      wr_data   = $urandom;
      dbg_we    = ($urandom % 4 == 0);
      dbg_wdata = $urandom;
      psr_we    = ($urandom % 4 == 0);
      psr_spsr  = ($urandom % 2 == 0);
      psr_mask  = ($urandom % 3 == 0) ? 4'd9 : 4'($urandom);
      psr_wdata = $urandom;
      step("R2");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule